// File: doc/BRIEF.md
# External interrupt request combiner

This block merges one dedicated active-low interrupt pin and the sixteen lines of two 8-bit general-purpose ports into a single pending interrupt request for a CPU. Every input is asynchronous. Each one passes through a two-flop synchronizer. A falling edge is then found by comparing the synchronized value with its value one cycle earlier.

A falling edge sets a sticky pending flag, and a CPU acknowledge pulse clears it. The dedicated pin has two trigger modes. In the first, only falling edges count. In the second, falling edges count and the request is also held while the pin stays low. The port lines always trigger on falling edges only, whatever mode is chosen, and they are only captured while the global enable is high.

The global enable also gates the request output. A dedicated-pin edge that arrives while the enable is low is still latched, and it shows on the output once the enable returns.

Top module: `ext_irq_combiner`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pending flag clears, `irq_req` reads 0 and every synchronizer stage and edge history bit goes to 1. A line that is high when reset is released produces no request.
- R2: A high-to-low transition on `irq_n` sets the pending flag. With `irq_en`=1, `irq_req` rises after the third rising clock edge that follows the input change (two synchronizer stages plus the edge register), and is still 0 after the second.
- R3: The pending flag holds until `ack` is sampled high at a rising edge with no new edge in that cycle. After that edge the flag is clear.
- R4: `lvl_mode`=1 selects edge-plus-level triggering: `irq_req` stays 1 while the synchronized `irq_n` is low, even after `ack`. `lvl_mode`=0 selects edge-only triggering: a pin held low raises no further request after `ack`.
- R5: A falling edge on any bit of `port_a` or `port_c` sets the pending flag while `irq_en`=1. A port line held low raises no further request after `ack`, even with `lvl_mode`=1.
- R6: Falling edges on port lines while `irq_en`=0 are ignored. No request appears after the enable is later set.
- R7: `irq_en`=0 forces `irq_req` to 0. A dedicated-pin falling edge seen during that time is still latched and raises `irq_req` once `irq_en` returns to 1.
- R8: If an edge event and `ack` fall in the same cycle, the edge wins and the pending flag is set after that edge.
- R9: Rising transitions on any line never raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_a | input | PORT_W (8) | First general-purpose port, falling-edge sources |
| port_c | input | PORT_W (8) | Second general-purpose port, falling-edge sources |
| irq_en | input | 1 | Global interrupt enable; masks the request and gates port capture |
| lvl_mode | input | 1 | 0: dedicated pin edge only; 1: edge plus low level |
| ack | input | 1 | CPU acknowledge, clears the pending flag |
| irq_req | output | 1 | Combined interrupt request to the CPU |

## Verification
On every cycle, the embedded properties check the pending flag: it holds until acknowledged, it is cleared by an acknowledge, an edge beats a coincident acknowledge, and port edges cannot set it while disabled. They also check that the request follows a low synchronized pin in level mode, that edge pulses last one cycle, and that the synchronizers reset to the idle-high state. The bench scenarios show what the properties cannot. These are the exact three-edge latency from pin to request, the edge-only behaviour of port lines in level mode, and a pin edge captured while masked that appears only after the enable returns. They also show that a reset in the middle of operation drops a pending request.

// File: rtl/irq_comb_pkg.sv
// Package: shared types and sizes for the interrupt request combiner.
// Assumes: consumers import it before their port lists.
package irq_comb_pkg;

    // Trigger selection for the dedicated pin.
    typedef enum logic {
        TRIG_EDGE       = 1'b0,
        TRIG_EDGE_LEVEL = 1'b1
    } trig_mode_e;

    localparam int unsigned DEF_PORT_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/irq_sync_chain.sv
// Module: irq_sync_chain
// Brings a vector of asynchronous lines into the clock domain through a
// chain of flip-flops. Every stage resets to all ones (the idle-high level
// of active-low lines), so the edge logic sees no transition after reset.
// Assumes: STAGES >= 2 and a synchronous, active-low reset.
module irq_sync_chain #(
    parameter int unsigned W      = 17,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the raw lines through the chain, idle-high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign sync_o = stg[STAGES-1];

    // R1: after a reset cycle the synchronized output is idle high.
    a_r1_sync_idle_high: assert property (@(posedge clk)
        !rst_n |=> (sync_o == '1));

endmodule

// File: rtl/irq_fall_detect.sv
// Module: irq_fall_detect
// Flags a one-cycle pulse per bit when a synchronized line goes from high
// (previous cycle) to low (current cycle). History resets to ones.
// Assumes: the input is already synchronous to clk.
module irq_fall_detect #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_q;

    // Remember last cycle's level for the edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;

    // R9: an edge pulse never lasts two consecutive cycles on one bit.
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: irq_pend_ctrl
// Holds the sticky pending flag and forms the request. The dedicated pin
// edge is always captured. Port edges are captured only while enabled.
// A coincident edge beats acknowledge. Level mode adds the low pin level.
// Assumes: all inputs are synchronous to clk.
module irq_pend_ctrl
    import irq_comb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_fall,
    input  logic port_fall,
    input  logic pin_lvl,
    input  logic irq_en,
    input  logic lvl_mode,
    input  logic ack,
    output logic irq_req
);

    trig_mode_e mode;
    logic       edge_evt;
    logic       pend_q;
    logic       lvl_hit;

    assign mode     = trig_mode_e'(lvl_mode);
    assign edge_evt = pin_fall | (irq_en & port_fall);
    assign lvl_hit  = (mode == TRIG_EDGE_LEVEL) & ~pin_lvl;

    // Set on any accepted edge, clear on acknowledge; the edge has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (edge_evt) pend_q <= 1'b1;
        else if (ack)      pend_q <= 1'b0;
    end

    // Request: latched edges or the live low level, masked by the enable.
    always_comb begin
        irq_req = irq_en & (pend_q | lvl_hit);
    end

    // R3: without acknowledge the flag holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack) |=> pend_q);
    // R3: acknowledge with no edge clears the flag.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pin_fall && !(irq_en && port_fall)) |=> !pend_q);
    // R8: a dedicated-pin edge sets the flag even with a coincident ack.
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> pend_q);
    // R6: while disabled, port edges alone cannot set the flag.
    a_r6_port_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !pin_fall && !pend_q) |=> !pend_q);
    // R4: in level mode a low synchronized pin keeps the request up.
    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && lvl_mode && !pin_lvl) |-> irq_req);

endmodule

// File: rtl/ext_irq_combiner.sv
// Module: ext_irq_combiner (top)
// Combines one active-low interrupt pin and two ports into one request.
// The lines are synchronized, edges are detected per line, the port edges
// are OR-reduced, and the result feeds the pending controller.
// Assumes: synchronous active-low reset; all pins are asynchronous.
module ext_irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic [PORT_W-1:0] port_a,
    input  logic [PORT_W-1:0] port_c,
    input  logic              irq_en,
    input  logic              lvl_mode,
    input  logic              ack,
    output logic              irq_req
);

    localparam int unsigned LINES = 1 + 2 * PORT_W;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic [LINES-1:0] fall_lines;
    logic             port_fall_any;

    assign raw_lines     = {port_c, port_a, irq_n};
    assign port_fall_any = |fall_lines[LINES-1:1];

    irq_sync_chain #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    irq_fall_detect #(
        .W (LINES)
    ) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_lines),
        .fall_o  (fall_lines)
    );

    irq_pend_ctrl u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_fall  (fall_lines[0]),
        .port_fall (port_fall_any),
        .pin_lvl   (sync_lines[0]),
        .irq_en    (irq_en),
        .lvl_mode  (lvl_mode),
        .ack       (ack),
        .irq_req   (irq_req)
    );

    // R7: a disabled block never shows a request.
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);

endmodule

// File: tb/tb_ext_irq_combiner.sv
// Bench: vector table walked by one loop, then directed corner cases.
module tb_ext_irq_combiner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_n = 1'b1;
    logic [7:0] port_a = 8'hFF;
    logic [7:0] port_c = 8'hFF;
    logic       irq_en = 1'b1;
    logic       lvl_mode = 1'b0;
    logic       ack = 1'b0;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    ext_irq_combiner dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .port_a   (port_a),
        .port_c   (port_c),
        .irq_en   (irq_en),
        .lvl_mode (lvl_mode),
        .ack      (ack),
        .irq_req  (irq_req)
    );

    // Entry: [20] lvl_mode [19] irq_en [18] irq_n [17:10] port_a
    //        [9:2] port_c [1] pulse ack [0] expected irq_req
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},  // 0  R9 idle
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1},  // 1  R2 pin fall
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0},  // 2  R4 edge mode, ack
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},  // 3  R9 pin rise
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1},  // 4  R4 level mode fall
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1},  // 5  R4 level after ack
        {1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0},  // 6  R4 level released
        {1'b1, 1'b1, 1'b1, 8'hF7, 8'hFF, 1'b0, 1'b1},  // 7  R5 port_a bit 3
        {1'b1, 1'b1, 1'b1, 8'hF7, 8'hFF, 1'b1, 1'b0},  // 8  R5 edge-only in level mode
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'h7F, 1'b0, 1'b1},  // 9  R5 port_c bit 7
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'h7F, 1'b1, 1'b0},  // 10 R3 ack clears
        {1'b0, 1'b0, 1'b1, 8'hFE, 8'hFF, 1'b0, 1'b0},  // 11 R6 port fall disabled
        {1'b0, 1'b1, 1'b1, 8'hFE, 8'hFF, 1'b0, 1'b0},  // 12 R6 not captured
        {1'b0, 1'b0, 1'b0, 8'hFE, 8'hFF, 1'b0, 1'b0},  // 13 R7 masked pin fall
        {1'b0, 1'b1, 1'b0, 8'hFE, 8'hFF, 1'b0, 1'b1},  // 14 R7 shown on enable
        {1'b0, 1'b1, 1'b0, 8'hFE, 8'hFF, 1'b1, 1'b0},  // 15 R3 ack clears
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0}   // 16 R9 all rise
    };

    function automatic string vec_req(int i);
        case (i)
            1:              return "R2";
            2, 4, 5, 6:     return "R4";
            7, 8, 9:        return "R5";
            10, 15:         return "R3";
            11, 12:         return "R6";
            13, 14:         return "R7";
            default:        return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_req !== exp) begin
            fails++;
            $display("FAIL %s: irq_req=%b expected %b", req, irq_req, exp);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: request low during reset.
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        settle();
        check("R1", 1'b0);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            lvl_mode = VEC[i][20];
            irq_en   = VEC[i][19];
            irq_n    = VEC[i][18];
            port_a   = VEC[i][17:10];
            port_c   = VEC[i][9:2];
            settle();
            if (VEC[i][1]) pulse_ack();
            check(vec_req(i), VEC[i][0]);
        end

        // R2: exact latency, low after two edges, high after three.
        irq_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", 1'b0);
        @(negedge clk);
        check("R2", 1'b1);
        pulse_ack();
        irq_n = 1'b1;
        settle();

        // R8: ack lands in the same cycle as the edge event.
        irq_n = 1'b0;
        repeat (2) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R8", 1'b1);
        pulse_ack();
        check("R3", 1'b0);
        irq_n = 1'b1;
        settle();

        // R1: reset in mid-operation drops a pending request.
        port_a = 8'hBF;
        settle();
        port_a = 8'hFF;
        settle();
        check("R3", 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        settle();
        check("R1", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule